// File: doc/BRIEF.md
# Reset Delay and Watchdog Controller

This block produces the held reset for the core of a small microcontroller. It runs entirely on an always-on slow clock that keeps ticking when the main processor clock is stopped. A reset delay counter keeps the core in reset for a fixed number of slow-clock cycles after the external reset pin is released. A free-running watchdog forces the core back into reset if software does not clear it in time.

Every watchdog timeout starts the same full delay again before the core may run. A timeout while the core is asleep also gives a one-cycle wake-up pulse. A status flag records whether the last reset came from the watchdog. The external pin, the sleep indication and the clear strobe come from other clock domains. Each passes through a two-flop synchronizer before it is used. The power-on indication `por_n` acts as the synchronous active-low reset of the whole block. The configuration bit `wdt_en` is treated as static.

Top module: `rst_wdt_ctrl`

## Requirements
- R1: While `por_n` is low, and from then until the delay completes, `core_rst_n` is 0, `wake_pulse` is 0 and `no_timeout` is 1. While the synchronized `ext_rst_n` is low, `core_rst_n` stays 0.
- R2: `ext_rst_n` is first sampled high at some rising edge of `slow_clk`. `core_rst_n` rises exactly DLY_CYCLES+1 edges later, counting the one synchronizer stage not yet passed and DLY_CYCLES count cycles.
- R3: If `ext_rst_n` is sampled low for even a single cycle during the delay or during normal running, `core_rst_n` goes to 0. The full delay then restarts from the next high sample.
- R4: With `wdt_en`=1 and no clear, the watchdog counts slow-clock cycles from the release of reset. `core_rst_n` falls exactly WDT_CYCLES+1 edges after it rose.
- R5: After a watchdog timeout, with the pin held high, `core_rst_n` stays 0 for exactly DLY_CYCLES cycles and then rises again.
- R6: While the synchronized `wdt_clr` is high, the watchdog count is held at zero. Clear strobes spaced closer than WDT_CYCLES cycles therefore prevent any timeout.
- R7: When `wdt_en` is 0, the watchdog never times out, and `core_rst_n` stays 1 indefinitely.
- R8: The watchdog keeps counting while the synchronized `sleep_in` is high. A timeout while asleep raises `wake_pulse` for exactly one cycle, in the same cycle that `core_rst_n` falls. A timeout while awake gives no `wake_pulse`.
- R9: `no_timeout` behaves as follows:
  - it goes to 0 in the cycle a watchdog reset asserts `core_rst_n`;
  - a synchronized clear sets it back to 1;
  - an external pin reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Always-on slow clock for all logic |
| por_n | input | 1 | Power-on indication, synchronous active-low reset of the block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sleep_in | input | 1 | Core is asleep with its main clock stopped, asynchronous |
| wdt_clr | input | 1 | Watchdog clear strobe from software, asynchronous |
| wdt_en | input | 1 | Watchdog enable configuration bit, static |
| core_rst_n | output | 1 | Held core reset, active low |
| wake_pulse | output | 1 | One-cycle pulse on a watchdog timeout during sleep |
| no_timeout | output | 1 | 0 after a watchdog reset, 1 after power-on or clear |

## Verification
The bench measures the delay from pin release to reset release, and from release to a watchdog timeout, to the exact cycle. An off-by-one in the counter compare or in the synchronizer depth shows up as a wrong length. It retriggers the pin while the delay is still counting, so a design that resumes the old count releases reset too early. A timeout is forced while asleep and another while awake, so a wake pulse that ignores sleep, or that lasts longer than one cycle, is caught. Three further cases are covered:
- the flag is watched across an external pin reset, so clearing it on every reset is caught;
- the enable bit is dropped, so a watchdog that still fires is caught;
- clear strobes are applied, so a count that is not held during clear fires anyway.

// File: rtl/rdw_pkg.sv
// Shared definitions for the reset delay / watchdog controller.
// Assumes: the three asynchronous inputs share one synchronizer bank,
// indexed by the positions below.
package rdw_pkg;
    localparam int SYNC_PIN   = 0;
    localparam int SYNC_SLEEP = 1;
    localparam int SYNC_CLR   = 2;
    localparam int SYNC_BITS  = 3;
endpackage

// File: rtl/rdw_sync.sv
// Bank of two-flop synchronizers into the slow-clock domain.
// Assumes: every input bit is a level held for at least one slow-clock
// cycle; the reset value of every stage is 0.
module rdw_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] stg;
        // Shift the asynchronous bit through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= 2'b00;
            else        stg <= {stg[0], d[i]};
        end
        assign q[i] = stg[1];
    end
endmodule

// File: rtl/rdw_delay.sv
// Reset delay counter: holds the core in reset until DLY_CYCLES cycles
// have elapsed with the pin released and no retrigger.
// Assumes: pin_ok is synchronous; retrig is a registered one-cycle pulse.
module rdw_delay #(
    parameter int DLY_CYCLES = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_ok,
    input  logic retrig,
    output logic released
);
    localparam int CW = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count up while released from external reset; release at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            released <= 1'b0;
        end else if (!pin_ok || retrig) begin
            cnt      <= '0;
            released <= 1'b0;
        end else if (!released) begin
            if (cnt == LAST) released <= 1'b1;
            else             cnt      <= cnt + 1'b1;
        end
    end

    // R1: a low pin always keeps the core in reset next cycle.
    assert_hold_on_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_ok |=> !released);
    // R2: release only ever follows the terminal count.
    assert_release_at_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!released && pin_ok && !retrig && cnt != LAST) |=> !released);
    // R5: a retrigger restarts the counter from zero.
    assert_retrig_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retrig |=> (cnt == '0 && !released));
endmodule

// File: rtl/rdw_wdog.sv
// Watchdog counter: counts slow-clock cycles while the core runs and
// emits a registered one-cycle timeout at WDT_CYCLES.
// Assumes: WDT_CYCLES >= 2; run is low whenever the core is in reset.
module rdw_wdog #(
    parameter int WDT_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic enable,
    input  logic clear,
    output logic tmo
);
    localparam int WW = (WDT_CYCLES > 1) ? $clog2(WDT_CYCLES) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WDT_CYCLES - 1);

    logic [WW-1:0] wcnt;

    // Advance the count; hold it clear in reset, when disabled or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            tmo  <= 1'b0;
        end else if (!run || !enable || clear) begin
            wcnt <= '0;
            tmo  <= 1'b0;
        end else if (wcnt == WLAST) begin
            wcnt <= '0;
            tmo  <= 1'b1;
        end else begin
            wcnt <= wcnt + 1'b1;
            tmo  <= 1'b0;
        end
    end

    // R4: the count never passes its terminal value.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= WLAST);
    // R7: a disabled watchdog produces no timeout.
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tmo);
    // R6: a clear suppresses the timeout in the next cycle.
    assert_clear_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tmo);
endmodule

// File: rtl/rst_wdt_ctrl.sv
// Top of the reset delay / watchdog controller. Synchronizes the
// asynchronous inputs, chains delay counter and watchdog, and keeps the
// wake pulse and timeout status flag.
// Assumes: por_n is the block's synchronous active-low reset; wdt_en is
// static configuration.
module rst_wdt_ctrl
    import rdw_pkg::*;
#(
    parameter int DLY_CYCLES = 18,
    parameter int WDT_CYCLES = 40
) (
    input  logic slow_clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic sleep_in,
    input  logic wdt_clr,
    input  logic wdt_en,
    output logic core_rst_n,
    output logic wake_pulse,
    output logic no_timeout
);
    logic [SYNC_BITS-1:0] raw_in;
    logic [SYNC_BITS-1:0] syn_in;
    logic                 released;
    logic                 tmo;

    assign raw_in[SYNC_PIN]   = ext_rst_n;
    assign raw_in[SYNC_SLEEP] = sleep_in;
    assign raw_in[SYNC_CLR]   = wdt_clr;

    rdw_sync #(.WIDTH(SYNC_BITS)) u_sync (
        .clk  (slow_clk),
        .rst_n(por_n),
        .d    (raw_in),
        .q    (syn_in)
    );

    rdw_delay #(.DLY_CYCLES(DLY_CYCLES)) u_delay (
        .clk     (slow_clk),
        .rst_n   (por_n),
        .pin_ok  (syn_in[SYNC_PIN]),
        .retrig  (tmo),
        .released(released)
    );

    rdw_wdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdog (
        .clk   (slow_clk),
        .rst_n (por_n),
        .run   (released),
        .enable(wdt_en),
        .clear (syn_in[SYNC_CLR]),
        .tmo   (tmo)
    );

    // Wake pulse and status flag follow the registered timeout.
    always_ff @(posedge slow_clk) begin
        if (!por_n) begin
            wake_pulse <= 1'b0;
            no_timeout <= 1'b1;
        end else begin
            wake_pulse <= tmo && syn_in[SYNC_SLEEP];
            if (tmo)                    no_timeout <= 1'b0;
            else if (syn_in[SYNC_CLR])  no_timeout <= 1'b1;
        end
    end

    assign core_rst_n = released;

    // R5: a timeout puts the core into reset in the next cycle.
    assert_tmo_resets_R5: assert property (@(posedge slow_clk) disable iff (!por_n)
        tmo |=> !core_rst_n);
    // R9: a timeout clears the status flag.
    assert_tmo_clears_flag_R9: assert property (@(posedge slow_clk) disable iff (!por_n)
        tmo |=> !no_timeout);
    // R8: a timeout while asleep yields a wake pulse.
    assert_sleep_wake_R8: assert property (@(posedge slow_clk) disable iff (!por_n)
        (tmo && syn_in[SYNC_SLEEP]) |=> wake_pulse);
    // R8: no wake pulse without a timeout.
    assert_wake_needs_tmo_R8: assert property (@(posedge slow_clk) disable iff (!por_n)
        !tmo |=> !wake_pulse);
endmodule

// File: tb/rst_wdt_ctrl_tb.sv
module rst_wdt_ctrl_tb;
    localparam int DLY = 18;
    localparam int WDT = 40;

    logic clk = 1'b0;
    logic por_n, ext_rst_n, sleep_in, wdt_clr, wdt_en;
    logic core_rst_n, wake_pulse, no_timeout;

    int total = 0;
    int failed = 0;
    bit done = 0;
    bit mdl_on = 0;

    always #10 clk = ~clk;

    rst_wdt_ctrl #(.DLY_CYCLES(DLY), .WDT_CYCLES(WDT)) u_dut (
        .slow_clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .sleep_in(sleep_in), .wdt_clr(wdt_clr), .wdt_en(wdt_en),
        .core_rst_n(core_rst_n), .wake_pulse(wake_pulse), .no_timeout(no_timeout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int pin_q[$], slp_q[$], clr_q[$];
    int m_cnt, m_rel, m_w, m_to, m_wake, m_flag;
    always @(posedge clk) begin
        int pin_s, slp_s, clr_s, hold;
        int n_cnt, n_rel, n_w, n_to, n_wake, n_flag;
        if (!por_n) begin
            pin_q = '{0, 0}; slp_q = '{0, 0}; clr_q = '{0, 0};
            m_cnt = 0; m_rel = 0; m_w = 0; m_to = 0; m_wake = 0; m_flag = 1;
        end else begin
            pin_s = pin_q[0]; slp_s = slp_q[0]; clr_s = clr_q[0];
            hold = (pin_s == 0) || (m_to == 1);
            n_cnt = m_cnt; n_rel = m_rel;
            if (hold) begin n_cnt = 0; n_rel = 0; end
            else if (m_rel == 0) begin
                if (m_cnt == DLY - 1) n_rel = 1; else n_cnt = m_cnt + 1;
            end
            if (m_rel == 0 || !wdt_en || clr_s == 1) begin n_w = 0; n_to = 0; end
            else if (m_w == WDT - 1) begin n_w = 0; n_to = 1; end
            else begin n_w = m_w + 1; n_to = 0; end
            n_wake = (m_to == 1 && slp_s == 1) ? 1 : 0;
            n_flag = (m_to == 1) ? 0 : (clr_s == 1) ? 1 : m_flag;
            void'(pin_q.pop_front()); pin_q.push_back(int'(ext_rst_n));
            void'(slp_q.pop_front()); slp_q.push_back(int'(sleep_in));
            void'(clr_q.pop_front()); clr_q.push_back(int'(wdt_clr));
            m_cnt = n_cnt; m_rel = n_rel; m_w = n_w; m_to = n_to;
            m_wake = n_wake; m_flag = n_flag;
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (mdl_on && !done) begin
            chk(int'(core_rst_n) == m_rel, "R2 model core_rst_n", int'(core_rst_n), m_rel);
            chk(int'(wake_pulse) == m_wake, "R8 model wake_pulse", int'(wake_pulse), m_wake);
            chk(int'(no_timeout) == m_flag, "R9 model no_timeout", int'(no_timeout), m_flag);
        end
    end

    // Count negedges until core_rst_n equals val; returns the count.
    task automatic wait_core(input logic val, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (core_rst_n !== val && k < 1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        int k, lows, wakes;
        por_n = 0; ext_rst_n = 0; sleep_in = 0; wdt_clr = 0; wdt_en = 1;
        repeat (4) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        mdl_on = 1;
        // R1: reset state after power-on, pin still low
        chk(core_rst_n == 0, "R1 core_rst_n after power-on", int'(core_rst_n), 0);
        chk(no_timeout == 1, "R1 no_timeout after power-on", int'(no_timeout), 1);
        chk(wake_pulse == 0, "R1 wake_pulse after power-on", int'(wake_pulse), 0);
        repeat (30) @(negedge clk);
        chk(core_rst_n == 0, "R1 core held while pin low", int'(core_rst_n), 0);

        // R2: release delay from pin high
        ext_rst_n = 1;
        wait_core(1'b1, k);
        chk(k == DLY + 2, "R2 release delay", k, DLY + 2);

        // R4: watchdog timeout with no clear and no sleep
        wait_core(1'b0, k);
        chk(k == WDT + 1, "R4 watchdog period", k, WDT + 1);
        chk(no_timeout == 0, "R9 flag cleared by timeout", int'(no_timeout), 0);
        chk(wake_pulse == 0, "R8 no wake when awake", int'(wake_pulse), 0);

        // R5: full delay retriggered by the timeout
        wait_core(1'b1, k);
        chk(k == DLY, "R5 retriggered delay", k, DLY);

        // R6: periodic clears prevent a timeout and set the flag
        lows = 0;
        for (int i = 0; i < 4 * WDT; i++) begin
            wdt_clr = (i % 20 == 0);
            @(negedge clk);
            if (core_rst_n == 0) lows++;
        end
        wdt_clr = 0;
        chk(lows == 0, "R6 no timeout under clears", lows, 0);
        chk(no_timeout == 1, "R9 flag set by clear", int'(no_timeout), 1);

        // R3: pin pulse restarts the delay, also mid-delay
        ext_rst_n = 0;
        @(negedge clk);
        ext_rst_n = 1;
        repeat (8) @(negedge clk);
        chk(core_rst_n == 0, "R3 pin pulse resets core", int'(core_rst_n), 0);
        ext_rst_n = 0;
        @(negedge clk);
        ext_rst_n = 1;
        wait_core(1'b1, k);
        chk(k == DLY + 2, "R3 delay restarts after mid-delay pulse", k, DLY + 2);

        // R8: timeout during sleep gives one wake pulse
        sleep_in = 1;
        wait_core(1'b0, k);
        chk(k == WDT + 1, "R8 watchdog counts in sleep", k, WDT + 1);
        chk(wake_pulse == 1, "R8 wake with reset", int'(wake_pulse), 1);
        wakes = 1;
        repeat (5) begin
            @(negedge clk);
            if (wake_pulse) wakes++;
        end
        chk(wakes == 1, "R8 wake lasts one cycle", wakes, 1);
        sleep_in = 0;
        wait_core(1'b1, k);

        // R9: pin reset leaves a cleared flag unchanged
        ext_rst_n = 0;
        @(negedge clk);
        ext_rst_n = 1;
        wait_core(1'b0, k);
        chk(no_timeout == 0, "R9 flag kept over pin reset", int'(no_timeout), 0);
        wait_core(1'b1, k);

        // R7: disabled watchdog never fires
        wdt_en = 0;
        lows = 0;
        repeat (3 * WDT) begin
            @(negedge clk);
            if (core_rst_n == 0) lows++;
        end
        chk(lows == 0, "R7 disabled watchdog quiet", lows, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule